// File: doc/BRIEF.md
# Flash Write-Status Output Generator

This block produces the data-bus status that a NOR-style flash device presents to its host while an internal program or erase algorithm runs. When a command is accepted it enters a status mode. In that mode, bit 7 gives a polling value: the inverse of the bit being programmed, or a fixed erase value. Bit 6 flips once per read strobe. Bit 5 is carried through from the timing-limit logic, and the low bits come from the array. When the operation ends, all eight bits revert to plain array data.

Commands aimed at a protected sector start no real work. The block instead shows a busy status for a fixed time and then returns to array reads. That time is about 2 µs for a program and about 100 µs for an erase, counted in clock cycles from a clock-rate parameter. The command decoder, the array and the other status bits are outside the block. They supply the request pulse, the operation kind, the busy and suspend flags, the address-match flag and the protection flag.

Top module: `flash_wstat_gen`

## Requirements
- R1: While no operation is active, including straight after reset, `dq_out` equals `array_dq` on all eight bits.
- R2: During an active program, a read with `addr_hit` high gives `dq_out[7]` = inverse of `tgt_d7`. This holds whatever the level of `erase_susp`, so programming inside a suspended erase obeys the same rule.
- R3: During an active erase, a read with `addr_hit` high gives `dq_out[7]` = 0 while `erase_susp` is low and 1 while it is high.
- R4: While active, `dq_out[4:0]` = `array_dq[4:0]` and `dq_out[5]` = `dq5_in`. With `addr_hit` low, `dq_out[7]` = `array_dq[7]`.
- R5: While active, the bit-6 status reg (0 after reset) inverts at the first clock edge that samples `oe_n` low after it was sampled high. It holds its value otherwise, and is shown on `dq_out[6]`.
- R6: Bit 6 does not invert while an erase is suspended. It also does not invert on a strobe falling edge sampled at the same edge that accepts a command.
- R7: A non-protected operation ends at the first edge that samples `busy` low, except during an erase while `erase_susp` is high. From then on R1 applies.
- R8: A program request with `sect_prot` high keeps status active for exactly CLK_MHZ*PROG_US cycles after the accepting edge, regardless of `busy`.
- R9: An erase request with `sect_prot` high keeps status active for exactly CLK_MHZ*ERASE_US cycles, with `dq_out[7]` = 0 at hit addresses when not suspended.
- R10: `op_start` while an operation is active is ignored. The latched operation kind does not change.
- R11: `op_start` sampled high while idle makes status active from the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse: command sequence accepted |
| op_is_erase | input | 1 | Operation kind at `op_start`: 1 erase, 0 program |
| sect_prot | input | 1 | Target sector(s) protected, sampled with `op_start` |
| busy | input | 1 | Internal algorithm running |
| erase_susp | input | 1 | Erase suspended |
| tgt_d7 | input | 1 | Bit 7 of the datum being programmed |
| addr_hit | input | 1 | Read address is the program address or inside a selected sector |
| oe_n | input | 1 | Output-enable read strobe, active low |
| dq5_in | input | 1 | Bit 5 status passed through |
| array_dq | input | 8 | Array read data |
| dq_out | output | 8 | Data bus value |

## Verification
Two events can fall on the same clock edge: a read strobe falling edge and the acceptance of a new command. The bench provokes this by driving `oe_n` low in the same cycle as `op_start`. It then checks that bit 6 still shows the value it had before the operation began. The bench also lets a strobe land while an erase is suspended and confirms that bit 6 holds. Each protected window is measured by counting the cycles in which the bit-7 polling value differs from array data.

// File: rtl/fwsg_pkg.sv
package fwsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_PROT = 2'd2
    } fw_state_e;

    typedef struct packed {
        fw_state_e st;
        logic      is_erase;
    } fw_ctx_t;

    // polling value for bit 7 at a hit address
    function automatic logic poll_bit(input logic is_erase, input logic susp,
                                      input logic tgt);
        return is_erase ? susp : ~tgt;
    endfunction

    function automatic int unsigned win_cycles(input int unsigned mhz,
                                               input int unsigned us);
        return mhz * us;
    endfunction

endpackage

// File: rtl/fwsg_ctrl.sv
module fwsg_ctrl
    import fwsg_pkg::*;
#(
    parameter int unsigned PROG_WIN  = 100,
    parameter int unsigned ERASE_WIN = 5000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    op_start,
    input  logic    op_is_erase,
    input  logic    sect_prot,
    input  logic    busy,
    input  logic    erase_susp,
    output fw_ctx_t ctx
);
    localparam int unsigned MAXW = (ERASE_WIN > PROG_WIN) ? ERASE_WIN : PROG_WIN;
    localparam int CW = $clog2(MAXW + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.st       <= ST_IDLE;
            ctx.is_erase <= 1'b0;
            cnt          <= '0;
        end else begin
            case (ctx.st)
                ST_IDLE: begin
                    if (op_start) begin
                        ctx.is_erase <= op_is_erase;
                        if (sect_prot) begin
                            ctx.st <= ST_PROT;
                            cnt    <= op_is_erase ? CW'(ERASE_WIN - 1)
                                                  : CW'(PROG_WIN - 1);
                        end else begin
                            ctx.st <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (!busy && !(ctx.is_erase && erase_susp))
                        ctx.st <= ST_IDLE;
                end
                ST_PROT: begin
                    if (cnt == '0) ctx.st <= ST_IDLE;
                    else           cnt    <= cnt - 1'b1;
                end
                default: ctx.st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fwsg_toggle.sv
module fwsg_toggle (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic freeze,
    input  logic oe_n,
    output logic tog
);
    logic oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b1;
            tog  <= 1'b0;
        end else begin
            oe_q <= oe_n;
            if (active && !freeze && oe_q && !oe_n)
                tog <= ~tog;
        end
    end

endmodule

// File: rtl/fwsg_mux.sv
module fwsg_mux
    import fwsg_pkg::*;
(
    input  logic       active,
    input  logic       is_erase,
    input  logic       susp,
    input  logic       tgt_d7,
    input  logic       addr_hit,
    input  logic       tog,
    input  logic       dq5_in,
    input  logic [7:0] array_dq,
    output logic [7:0] dq_out
);
    always_comb begin
        dq_out = array_dq;
        if (active) begin
            dq_out[5] = dq5_in;
            dq_out[6] = tog;
            if (addr_hit) dq_out[7] = poll_bit(is_erase, susp, tgt_d7);
        end
    end

endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
    import fwsg_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 50,
    parameter int unsigned PROG_US  = 2,
    parameter int unsigned ERASE_US = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       op_start,
    input  logic       op_is_erase,
    input  logic       sect_prot,
    input  logic       busy,
    input  logic       erase_susp,
    input  logic       tgt_d7,
    input  logic       addr_hit,
    input  logic       oe_n,
    input  logic       dq5_in,
    input  logic [7:0] array_dq,
    output logic [7:0] dq_out
);
    localparam int unsigned PROG_WIN  = win_cycles(CLK_MHZ, PROG_US);
    localparam int unsigned ERASE_WIN = win_cycles(CLK_MHZ, ERASE_US);

    fw_ctx_t ctx;
    logic    active;
    logic    tog;

    assign active = (ctx.st != ST_IDLE);

    fwsg_ctrl #(.PROG_WIN(PROG_WIN), .ERASE_WIN(ERASE_WIN)) u_ctrl (
        .clk(clk), .rst(rst), .op_start(op_start), .op_is_erase(op_is_erase),
        .sect_prot(sect_prot), .busy(busy), .erase_susp(erase_susp), .ctx(ctx)
    );

    fwsg_toggle u_tog (
        .clk(clk), .rst(rst), .active(active),
        .freeze(ctx.is_erase && erase_susp), .oe_n(oe_n), .tog(tog)
    );

    fwsg_mux u_mux (
        .active(active), .is_erase(ctx.is_erase), .susp(erase_susp),
        .tgt_d7(tgt_d7), .addr_hit(addr_hit), .tog(tog), .dq5_in(dq5_in),
        .array_dq(array_dq), .dq_out(dq_out)
    );

endmodule

// File: rtl/fwsg_chk.sv
module fwsg_chk
    import fwsg_pkg::*;
#(
    parameter int unsigned ERASE_WIN = 5000
) (
    input logic       clk,
    input logic       rst,
    input logic       op_start,
    input logic       oe_n,
    input logic       erase_susp,
    input logic       tgt_d7,
    input logic       addr_hit,
    input logic       dq5_in,
    input logic [7:0] array_dq,
    input logic [7:0] dq_out,
    input fw_state_e  st,
    input logic       is_erase,
    input logic       tog
);
    localparam int CW = $clog2(ERASE_WIN + 2);
    logic [CW-1:0] prot_len;

    always_ff @(posedge clk) begin
        if (rst || st != ST_PROT) prot_len <= '0;
        else if (prot_len <= CW'(ERASE_WIN)) prot_len <= prot_len + 1'b1;
    end

    // R1
    idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE |-> dq_out == array_dq);

    // R2
    prog_bit7_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && !is_erase && addr_hit) |-> dq_out[7] == !tgt_d7);

    // R3
    erase_bit7_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && is_erase && addr_hit) |-> dq_out[7] == erase_susp);

    // R4
    low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        st != ST_IDLE |-> (dq_out[4:0] == array_dq[4:0] && dq_out[5] == dq5_in));

    // R5 R6
    tog_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tog) |-> ($past(st != ST_IDLE && !(is_erase && erase_susp) && !oe_n)
                           && $past(oe_n, 2)));

    // R8 R9
    prot_len_chk: assert property (@(posedge clk) disable iff (rst)
        prot_len <= CW'(ERASE_WIN));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && op_start) |=> $stable(is_erase));

    // R11
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && op_start) |=> st != ST_IDLE);

endmodule

bind flash_wstat_gen fwsg_chk #(.ERASE_WIN(ERASE_WIN)) u_chk (
    .clk(clk), .rst(rst), .op_start(op_start), .oe_n(oe_n),
    .erase_susp(erase_susp), .tgt_d7(tgt_d7), .addr_hit(addr_hit),
    .dq5_in(dq5_in), .array_dq(array_dq), .dq_out(dq_out),
    .st(ctx.st), .is_erase(ctx.is_erase), .tog(tog)
);

// File: tb/sim_flash_wstat_gen.sv
module sim_flash_wstat_gen;
    localparam int unsigned MHZ = 4;
    localparam int unsigned PW  = MHZ * 2;
    localparam int unsigned EW  = MHZ * 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_start = 0, op_is_erase = 0, sect_prot = 0, busy = 0, erase_susp = 0;
    logic tgt_d7 = 0, addr_hit = 0, oe_n = 1, dq5_in = 0;
    logic [7:0] array_dq = 8'h00;
    logic [7:0] dq_out;

    int checks = 0;
    int errors = 0;
    logic exp_tog = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_wstat_gen #(.CLK_MHZ(MHZ)) u0 (
        .clk(clk), .rst(rst), .op_start(op_start), .op_is_erase(op_is_erase),
        .sect_prot(sect_prot), .busy(busy), .erase_susp(erase_susp),
        .tgt_d7(tgt_d7), .addr_hit(addr_hit), .oe_n(oe_n), .dq5_in(dq5_in),
        .array_dq(array_dq), .dq_out(dq_out)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // one read strobe; toggles when flip is set
    task automatic strobe(input bit flip, input string req);
        oe_n = 1'b0;
        cyc();
        if (flip) exp_tog = ~exp_tog;
        chk(req, {7'd0, dq_out[6]}, {7'd0, exp_tog});
        oe_n = 1'b1;
        cyc();
        chk(req, {7'd0, dq_out[6]}, {7'd0, exp_tog});
    endtask

    task automatic start_op(input logic erase, input logic prot);
        op_is_erase = erase;
        sect_prot   = prot;
        op_start    = 1'b1;
        cyc();
        op_start    = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state and sweep
        for (int i = 0; i < 256; i++) begin
            array_dq = 8'(i);
            dq5_in = ~i[5];
            tgt_d7 = i[0];
            addr_hit = i[1];
            #1;
            chk("R1", dq_out, array_dq);
        end

        // R11 + R6: strobe falls on the accepting edge -> no toggle
        busy = 1'b1;
        oe_n = 1'b0;
        start_op(1'b0, 1'b0);
        oe_n = 1'b1;
        cyc();
        chk("R11", {7'd0, dq_out[6]}, {7'd0, exp_tog});
        addr_hit = 1'b1; tgt_d7 = 1'b1; array_dq = 8'h80;
        #1;
        chk("R11", {7'd0, dq_out[7]}, 8'd0);

        // R2 / R4 sweep over program status
        for (int i = 0; i < 64; i++) begin
            logic [7:0] a;
            logic [7:0] e;
            a = {i[5], i[4], i[3] ^ i[5], i[2], 1'b1, i[1], i[3], i[4]};
            tgt_d7 = i[0];
            addr_hit = i[1];
            erase_susp = i[2];
            dq5_in = i[3];
            array_dq = a;
            #1;
            e = a;
            e[5] = i[3];
            e[6] = exp_tog;
            if (i[1]) e[7] = ~i[0];
            chk(i[1] ? "R2" : "R4", dq_out, e);
        end
        erase_susp = 1'b0;
        addr_hit = 1'b1;

        // R5 toggling
        for (int k = 0; k < 5; k++) strobe(1'b1, "R5");
        repeat (3) cyc();
        chk("R5", {7'd0, dq_out[6]}, {7'd0, exp_tog});

        // R7 end of program
        array_dq = 8'h3C;
        busy = 1'b0;
        #1;
        chk("R7", {7'd0, dq_out[7]}, {7'd0, ~tgt_d7});
        cyc();
        chk("R7", dq_out, 8'h3C);

        // erase, R3 / R6 / R10
        busy = 1'b1;
        array_dq = 8'hFF;
        start_op(1'b1, 1'b0);
        #1;
        chk("R3", {7'd0, dq_out[7]}, 8'd0);
        strobe(1'b1, "R5");
        tgt_d7 = 1'b0;
        start_op(1'b0, 1'b0);
        #1;
        chk("R10", {7'd0, dq_out[7]}, 8'd0);
        erase_susp = 1'b1;
        busy = 1'b0;
        #1;
        chk("R3", {7'd0, dq_out[7]}, 8'd1);
        strobe(1'b0, "R6");
        strobe(1'b0, "R6");
        cyc();
        chk("R7", {7'd0, dq_out[7]}, 8'd1);
        erase_susp = 1'b0;
        busy = 1'b1;
        cyc();
        strobe(1'b1, "R5");
        busy = 1'b0;
        cyc();
        chk("R7", dq_out, 8'hFF);

        // R8 protected program window
        addr_hit = 1'b1; tgt_d7 = 1'b0; array_dq = 8'h00; busy = 1'b0;
        start_op(1'b0, 1'b1);
        n = 0;
        while (dq_out[7] && n < 2000) begin n++; cyc(); end
        chk("R8", 8'(n), 8'(PW));
        chk("R8", dq_out, 8'h00);

        // R9 protected erase window
        array_dq = 8'h80;
        start_op(1'b1, 1'b1);
        n = 0;
        while (!dq_out[7] && n < 2000) begin n++; cyc(); end
        checks++;
        if (n != EW) begin
            errors++;
            $display("FAIL R9: got %0d expected %0d", n, EW);
        end
        chk("R9", dq_out, 8'h80);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule